// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns one of two free-running master audio clock enables (a 44.1 kHz family and a 48 kHz family) into a sample-rate strobe. It uses an error accumulator: every time the selected master enable fires, the step value is added. Whenever the running sum reaches the modulus, the modulus is taken off again and a single-cycle strobe is issued. The mean strobe rate is therefore master × step / modulus. With a step of 4 and modulus = 4 × master / rate, any audio rate from 8000 Hz to 48000 Hz can be produced. The master is picked as whichever of 44100 and 48000 leaves the smaller remainder when divided by the wanted rate.

Two registers configure the block. One is a 16-bit source select. The other is a 32-bit word that carries the step in its low half. Its high half holds the modulus in a pre-negated form, (step − modulus − 1) mod 2^16, and the datapath decodes the modulus from that form. Writing either register restarts the strobe stream from an empty accumulator. A playback path and a record path each use their own instance.

Top module: `bres_rate_gen`

## Requirements
- R1: After reset the select register holds 0 (48 kHz family), step and pre-negated term are 0 (so the modulus is 0xFFFF), the accumulator is 0, and both rate_stb_o and cfg_err_o are low; enables produce no strobe in this state.
- R2: Writing select value 16'd1 makes the accumulator count only mclk_a_en_i (44.1 kHz family). Any other value makes it count only mclk_b_en_i (48 kHz family). Enables from the unselected master have no effect.
- R3: The configuration word carries the step in bits 15:0 and (step − modulus − 1) mod 2^16 in bits 31:16. The block uses modulus = step − bits[31:16] − 1, computed mod 2^16.
- R4: On a selected enable, sum = acc + step. If sum ≥ modulus, acc becomes sum − modulus and rate_stb_o is high for exactly the next cycle. Otherwise acc becomes sum and no strobe is issued. Without an enable or a write, acc holds its value.
- R5: Starting from a cleared accumulator, N selected enables give exactly floor(N × step / modulus) strobes.
- R6: A write to either register clears the accumulator. The cycle after the write carries no strobe, even when an enable arrives together with the write.
- R7: When the modulus is 0 or smaller than the step, cfg_err_o is high from the cycle after the write, and no strobe is issued while it stays high.
- R8: When the step equals the modulus, every selected enable yields a strobe.
- R9: Moduli 4 × master / rate, for any rate from 8000 to 48000 Hz and its master, are handled without error.
- R10: The select decode uses all 16 bits: values such as 3 or 0x8001 select the 48 kHz family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mclk_a_en_i | input | 1 | One-cycle enable from the 44.1 kHz master |
| mclk_b_en_i | input | 1 | One-cycle enable from the 48 kHz master |
| sel_wr_i | input | 1 | Write strobe for the source select register |
| sel_wdata_i | input | 16 | Source select write value |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | {pre-negated modulus term, step} |
| rate_stb_o | output | 1 | One-cycle sample-rate strobe |
| cfg_err_o | output | 1 | Modulus zero or below the step |

## Verification
The bench goes after the decode of the pre-negated modulus. A design that stored the high half directly, or dropped the extra minus one, would drift away from the strobe count the bench expects within a few enables. It checks writes that land on the same cycle as an enable: a design that let the enable win would issue a stray strobe or leave a residue in the accumulator. It also covers the step equal to the modulus, a modulus of zero and a modulus below the step. A wrong comparison there would miss strobes, hang, or issue strobes while cfg_err_o is high. Select values other than 1 check that only the exact value 1 picks the 44.1 kHz family.

// File: rtl/bres_pkg.sv
`timescale 1ns/1ps
package bres_pkg;

    typedef enum logic {
        SRC_48K = 1'b0,
        SRC_44K = 1'b1
    } mclk_src_e;

endpackage

// File: rtl/bres_cfg_regs.sv
`timescale 1ns/1ps
module bres_cfg_regs #(
    parameter int SEL_W = 16,
    parameter int ACC_W = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sel_wr_i,
    input  logic [SEL_W-1:0]     sel_wdata_i,
    input  logic                 cfg_wr_i,
    input  logic [2*ACC_W-1:0]   cfg_wdata_i,
    output bres_pkg::mclk_src_e  src_o,
    output logic [ACC_W-1:0]     step_o,
    output logic [ACC_W-1:0]     negm_o,
    output logic                 restart_o
);
    import bres_pkg::*;

    localparam logic [SEL_W-1:0] SEL_PICK_A = SEL_W'(1);

    typedef struct packed {
        mclk_src_e        src;
        logic [ACC_W-1:0] step;
        logic [ACC_W-1:0] negm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sel_wr_i) begin
            cfg_d.src = (sel_wdata_i == SEL_PICK_A) ? SRC_44K : SRC_48K;
        end
        if (cfg_wr_i) begin
            cfg_d.step = cfg_wdata_i[ACC_W-1:0];
            cfg_d.negm = cfg_wdata_i[2*ACC_W-1:ACC_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '{src: SRC_48K, step: '0, negm: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src_o     = cfg_q.src;
    assign step_o    = cfg_q.step;
    assign negm_o    = cfg_q.negm;
    assign restart_o = sel_wr_i | cfg_wr_i;

endmodule

// File: rtl/bres_mod_decode.sv
`timescale 1ns/1ps
module bres_mod_decode #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] step_i,
    input  logic [ACC_W-1:0] negm_i,
    output logic [ACC_W-1:0] mod_o,
    output logic             bad_o
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

    logic [ACC_W-1:0] mod_w;

    always_comb begin
        // modulus = step - term - 1, wrapping at 2^ACC_W
        mod_w = step_i - negm_i - ONE;
        bad_o = (mod_w == '0) || (mod_w < step_i);
        mod_o = mod_w;
    end

endmodule

// File: rtl/bres_accum.sv
`timescale 1ns/1ps
module bres_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic [ACC_W-1:0] step_i,
    input  logic [ACC_W-1:0] mod_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             stb_o
);
    localparam int SUM_W = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             stb;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] mod_x;

    always_comb begin
        sum_w  = {1'b0, st_q.acc} + {1'b0, step_i};
        mod_x  = {1'b0, mod_i};
        st_d   = st_q;
        st_d.stb = 1'b0;
        if (restart_i) begin
            st_d.acc = '0;
        end else if (tick_i && !hold_i) begin
            if (sum_w >= mod_x) begin
                st_d.acc = ACC_W'(sum_w - mod_x);
                st_d.stb = 1'b1;
            end else begin
                st_d.acc = ACC_W'(sum_w);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{acc: '0, stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
    assign stb_o = st_q.stb;

endmodule

// File: rtl/bres_rate_gen.sv
`timescale 1ns/1ps
module bres_rate_gen #(
    parameter int SEL_W = 16,
    parameter int ACC_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               mclk_a_en_i,
    input  logic               mclk_b_en_i,
    input  logic               sel_wr_i,
    input  logic [SEL_W-1:0]   sel_wdata_i,
    input  logic               cfg_wr_i,
    input  logic [2*ACC_W-1:0] cfg_wdata_i,
    output logic               rate_stb_o,
    output logic               cfg_err_o
);
    import bres_pkg::*;

    mclk_src_e        src_w;
    logic [ACC_W-1:0] step_w;
    logic [ACC_W-1:0] negm_w;
    logic [ACC_W-1:0] mod_w;
    logic [ACC_W-1:0] acc_w;
    logic             restart_w;
    logic             bad_w;
    logic             tick_w;

    bres_cfg_regs #(.SEL_W(SEL_W), .ACC_W(ACC_W)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_wr_i    (sel_wr_i),
        .sel_wdata_i (sel_wdata_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .src_o       (src_w),
        .step_o      (step_w),
        .negm_o      (negm_w),
        .restart_o   (restart_w)
    );

    bres_mod_decode #(.ACC_W(ACC_W)) u_dec (
        .step_i (step_w),
        .negm_i (negm_w),
        .mod_o  (mod_w),
        .bad_o  (bad_w)
    );

    assign tick_w = (src_w == SRC_44K) ? mclk_a_en_i : mclk_b_en_i;

    bres_accum #(.ACC_W(ACC_W)) u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart_w),
        .tick_i    (tick_w),
        .hold_i    (bad_w),
        .step_i    (step_w),
        .mod_i     (mod_w),
        .acc_o     (acc_w),
        .stb_o     (rate_stb_o)
    );

    assign cfg_err_o = bad_w;

endmodule

// File: rtl/bres_rate_gen_chk.sv
`timescale 1ns/1ps
module bres_rate_gen_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mclk_a_en_i,
    input logic             mclk_b_en_i,
    input logic             sel_wr_i,
    input logic             cfg_wr_i,
    input logic             rate_stb_o,
    input logic             cfg_err_o,
    input logic [ACC_W-1:0] acc_w,
    input logic [ACC_W-1:0] mod_w
);
    // R4: a strobe only follows an enable on the previous edge
    a_r4_stb_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rate_stb_o |-> $past(mclk_a_en_i || mclk_b_en_i));

    // R7: no strobe comes out of a cycle that was flagged bad
    a_r7_err_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rate_stb_o |-> !$past(cfg_err_o));

    // R6: a register write is never followed by a strobe
    a_r6_write_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_wr_i || cfg_wr_i) |=> !rate_stb_o);

    // R4: residue stays below the decoded modulus
    a_r4_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_err_o |-> (acc_w < mod_w));

    // R4: idle cycles leave the accumulator alone
    a_r4_acc_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mclk_a_en_i && !mclk_b_en_i && !sel_wr_i && !cfg_wr_i) |=> $stable(acc_w));

endmodule

bind bres_rate_gen bres_rate_gen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mclk_a_en_i (mclk_a_en_i),
    .mclk_b_en_i (mclk_b_en_i),
    .sel_wr_i    (sel_wr_i),
    .cfg_wr_i    (cfg_wr_i),
    .rate_stb_o  (rate_stb_o),
    .cfg_err_o   (cfg_err_o),
    .acc_w       (acc_w),
    .mod_w       (mod_w)
);

// File: tb/bres_rate_gen_bench.sv
`timescale 1ns/1ps
module bres_rate_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 1'b0, b_en = 1'b0;
    logic        sel_wr = 1'b0, cfg_wr = 1'b0;
    logic [15:0] sel_data = '0;
    logic [31:0] cfg_data = '0;
    logic        stb, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    bit          m_a = 1'b0;
    logic [15:0] m_step = '0, m_negm = '0, m_acc = '0;
    bit          m_stb = 1'b0;
    int          stb_seen = 0;

    always #2.5 clk = ~clk;

    bres_rate_gen u_bres_rate_gen (
        .clk_i(clk), .rst_ni(rst_n), .mclk_a_en_i(a_en), .mclk_b_en_i(b_en),
        .sel_wr_i(sel_wr), .sel_wdata_i(sel_data), .cfg_wr_i(cfg_wr),
        .cfg_wdata_i(cfg_data), .rate_stb_o(stb), .cfg_err_o(err)
    );

    function automatic logic [15:0] f_mod(input logic [15:0] s, input logic [15:0] n);
        return s - n - 16'd1;
    endfunction

    function automatic bit f_bad(input logic [15:0] s, input logic [15:0] n);
        logic [15:0] m = f_mod(s, n);
        return (m == 16'd0) || (m < s);
    endfunction

    function automatic logic [31:0] f_word(input logic [15:0] s, input logic [15:0] m);
        logic [15:0] hi = s - m - 16'd1;
        return {hi, s};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit ta, input bit tb,
                        input bit sw, input logic [15:0] sd,
                        input bit cw, input logic [31:0] cd);
        logic [16:0] sum;
        logic [15:0] md;
        bit tk;
        @(negedge clk);
        a_en = ta; b_en = tb; sel_wr = sw; sel_data = sd; cfg_wr = cw; cfg_data = cd;
        @(posedge clk);
        if (sw || cw) begin
            m_acc = '0; m_stb = 1'b0;
            if (sw) m_a = (sd == 16'd1);
            if (cw) begin m_step = cd[15:0]; m_negm = cd[31:16]; end
        end else begin
            tk = m_a ? ta : tb;
            md = f_mod(m_step, m_negm);
            m_stb = 1'b0;
            if (tk && !f_bad(m_step, m_negm)) begin
                sum = {1'b0, m_acc} + {1'b0, m_step};
                if (sum >= {1'b0, md}) begin
                    m_acc = 16'(sum - {1'b0, md});
                    m_stb = 1'b1;
                end else begin
                    m_acc = sum[15:0];
                end
            end
        end
        #1;
        if (stb) stb_seen++;
        chk(tag, "strobe", int'(stb), int'(m_stb));
        chk(tag, "cfg_err", int'(err), int'(f_bad(m_step, m_negm)));
        a_en = 1'b0; b_en = 1'b0; sel_wr = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic burst(input string tag, input int n, input bit use_a, input int exp_cnt);
        stb_seen = 0;
        for (int i = 0; i < n; i++) begin
            step(tag, use_a, !use_a, 1'b0, '0, 1'b0, '0);
            step(tag, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
        end
        step(tag, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
        chk(tag, "strobe count", stb_seen, exp_cnt);
    endtask

    initial begin
        int rate, mst, md, stp;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state
        chk("R1", "strobe after reset", int'(stb), 0);
        chk("R1", "cfg_err after reset", int'(err), 0);
        burst("R1", 10, 1'b0, 0);

        // R5 / R9: 8000 Hz from 44.1 kHz family, step 4 modulus 22
        step("R2", 0, 0, 1, 16'd1, 0, '0);
        step("R3", 0, 0, 0, '0, 1, f_word(16'd4, 16'd22));
        burst("R5", 220, 1'b1, 40);
        // R2: unselected master ignored
        burst("R2", 30, 1'b0, 0);

        // R3: odd step and modulus
        step("R3", 0, 0, 0, '0, 1, f_word(16'd3, 16'd7));
        burst("R3", 70, 1'b1, 30);

        // R10: other select values choose the 48 kHz family
        step("R10", 0, 0, 1, 16'h8001, 0, '0);
        burst("R10", 20, 1'b1, 0);
        step("R10", 0, 0, 1, 16'd3, 0, '0);
        burst("R10", 21, 1'b0, 9);

        // R8: step equals modulus
        step("R8", 0, 0, 0, '0, 1, f_word(16'd4, 16'd4));
        burst("R8", 16, 1'b0, 16);

        // R6: write together with enable
        step("R6", 1, 1, 0, '0, 1, f_word(16'd4, 16'd4));
        step("R6", 1, 1, 1, 16'd0, 0, '0);
        step("R6", 0, 1, 0, '0, 0, '0);

        // R7: modulus zero, then modulus below step
        step("R7", 0, 0, 0, '0, 1, f_word(16'd4, 16'd0));
        burst("R7", 8, 1'b0, 0);
        step("R7", 0, 0, 0, '0, 1, f_word(16'd4, 16'd3));
        burst("R7", 8, 1'b0, 0);

        // R4 / R9: random legal rates with random enables and occasional bad words
        for (int k = 0; k < 40; k++) begin
            rate = 8000 + int'($urandom % 40001);
            mst = ((44100 % rate) < (48000 % rate)) ? 44100 : 48000;
            md = 4 * mst / rate;
            if ($urandom % 8 == 0) begin
                stp = 1 + int'($urandom % 8);
                md = int'($urandom % 31);
            end else begin
                stp = 4;
            end
            step("R9", 0, 0, 1, (mst == 44100) ? 16'd1 : 16'd0, 0, '0);
            step("R9", 0, 0, 0, '0, 1, f_word(16'(stp), 16'(md)));
            for (int c = 0; c < 60; c++) begin
                step("R4", ($urandom % 3) == 0, ($urandom % 3) == 0, 0, '0, 0, '0);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule